// File: doc/BRIEF.md
# Ternary Bitwise Logic Unit

This execute stage evaluates any three-input, one-output Boolean function bit by bit over a 64-bit word. The function is named by an 8-bit truth table that arrives with the operation. The three inputs to the function are the destination register's previous contents, a first source and a second source. The result is meant to overwrite that destination. At every bit position the unit builds a 3-bit selector from the matching bits of the three operands and uses it to pick one bit of the table. The same table applies to every position.

Decode hands the unit its fields that have already been extracted, together with a valid strobe. The unit captures them at that clock edge and presents the registered result, with its valid flag, in the next cycle. When the record flag is set, the unit also produces a 4-bit condition field from a signed comparison of the result against zero, with the summary-overflow bit copied in. With the record flag clear, the condition output keeps its old value.

Top module: `tern_logic_unit`

## Requirements
- R1: For bit position i, the selector is sel = {oldDst[i], srcA[i], srcB[i]}, where oldDst is the most significant bit and srcB is the least significant. Result bit i equals truthTbl[7 - sel]. Here truthTbl is counted from its least significant bit, so sel 0 picks truthTbl[7] and sel 7 picks truthTbl[0].
- R2: Each of the 256 table values gives, at every one of the 64 positions independently, the function that R1 defines.
- R3: Table 0x00 gives an all-zero result and table 0xFF gives an all-ones result, whatever the operands are.
- R4: Table 0x1B gives a bitwise multiplexer: result = (srcA & srcB) | (oldDst & ~srcB). The tables 0x11, 0x77 and 0x66 give srcA AND srcB, srcA OR srcB and srcA XOR srcB, with oldDst ignored.
- R5: resValid is high in the cycle right after a cycle in which inValid was sampled high, and low otherwise. result then carries the value computed from the operands sampled on that edge.
- R6: When inValid and recordEn are both sampled high, condValid goes high in the next cycle and condField is loaded. Its bits are: bit 3 = result negative (signed), bit 2 = result positive, bit 1 = result zero, bit 0 = sumOvf. Exactly one of bits 3 to 1 is set.
- R7: When an operation is accepted with recordEn low, condValid stays low and condField keeps its previous value.
- R8: While rstN is low at a clock edge, resValid, condValid, result and condField are all cleared to zero.
- R9: While inValid is low, changes on the operand, table, record and overflow inputs do not alter result or condField.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Operation fields are valid this cycle |
| oldDst | input | 64 | Previous destination value (most significant selector input) |
| srcA | input | 64 | First source operand |
| srcB | input | 64 | Second source operand (least significant selector input) |
| truthTbl | input | 8 | Truth table of the function |
| recordEn | input | 1 | Request a condition field update |
| sumOvf | input | 1 | Summary-overflow bit to copy into the condition field |
| resValid | output | 1 | result holds a new value |
| result | output | 64 | Registered function result |
| condValid | output | 1 | condField was updated by the last operation |
| condField | output | 4 | {negative, positive, zero, overflow copy} |

## Verification
A wrong selector order or a bit-reversed table shows up in the very first result cycle as a mismatch against the sum-of-products model, for almost every table value. A stuck or skewed valid register shows up as resValid or condValid out of step with the accepted strobe, one cycle after issue. A condition register that loads when it should not shows up only in the next cycle where condField is sampled after a non-recording operation. The bench therefore reads condField right after such operations.

// File: rtl/tlu_pkg.sv
package tlu_pkg;
  localparam int SEL_W = 3;
  localparam int TBL_W = 1 << SEL_W;
  localparam int CND_W = 4;

  // condition field bit positions
  localparam int CND_NEG = 3;
  localparam int CND_POS = 2;
  localparam int CND_ZERO = 1;
  localparam int CND_OVF = 0;

  typedef struct packed {
    logic resLoad;
    logic condLoad;
  } tluStrobe_t;
endpackage

// File: rtl/tlu_ctrl.sv
module tlu_ctrl
  import tlu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       recordEn,
  output tluStrobe_t strb,
  output logic       resValid,
  output logic       condValid
);
  always_comb begin
    strb.resLoad  = inValid;
    strb.condLoad = inValid & recordEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid  <= 1'b0;
      condValid <= 1'b0;
    end else begin
      resValid  <= strb.resLoad;
      condValid <= strb.condLoad;
    end
  end

  p_res_latency_r5: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> resValid);
  p_res_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !resValid);
  p_cond_needs_res_r6: assert property (@(posedge clk) disable iff (!rstN)
    condValid |-> resValid);
  p_no_cond_unrecorded_r7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !recordEn) |=> !condValid);
endmodule

// File: rtl/tlu_datapath.sv
module tlu_datapath
  import tlu_pkg::*;
#(
  parameter int XLEN = 64
)(
  input  logic             clk,
  input  logic             rstN,
  input  tluStrobe_t       strb,
  input  logic [XLEN-1:0]  oldDst,
  input  logic [XLEN-1:0]  srcA,
  input  logic [XLEN-1:0]  srcB,
  input  logic [TBL_W-1:0] truthTbl,
  input  logic             sumOvf,
  output logic [XLEN-1:0]  resQ,
  output logic [CND_W-1:0] condQ
);
  logic [XLEN-1:0]  bitRes;
  logic [CND_W-1:0] condNext;

  // one table lookup per bit position
  for (genvar i = 0; i < XLEN; i++) begin : g_slice
    logic [SEL_W-1:0] sel;
    assign sel       = {oldDst[i], srcA[i], srcB[i]};
    assign bitRes[i] = truthTbl[SEL_W'(TBL_W - 1) - sel];
  end

  always_comb begin
    condNext           = '0;
    condNext[CND_NEG]  = $signed(bitRes) < 0;
    condNext[CND_POS]  = $signed(bitRes) > 0;
    condNext[CND_ZERO] = (bitRes == '0);
    condNext[CND_OVF]  = sumOvf;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resQ  <= '0;
      condQ <= '0;
    end else begin
      if (strb.resLoad)  resQ  <= bitRes;
      if (strb.condLoad) condQ <= condNext;
    end
  end

  p_zero_table_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.resLoad && truthTbl == '0) |=> (resQ == '0));
  p_ones_table_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.resLoad && truthTbl == '1) |=> (resQ == '1));
  p_res_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.resLoad |=> $stable(resQ));
  p_cond_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.condLoad |=> $stable(condQ));
  p_zero_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.condLoad |=> (condQ[CND_ZERO] == (resQ == '0)));
  p_one_sign_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.condLoad |=> ($countones(condQ[CND_NEG:CND_ZERO]) == 1));
endmodule

// File: rtl/tern_logic_unit.sv
module tern_logic_unit
  import tlu_pkg::*;
#(
  parameter int XLEN = 64
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [XLEN-1:0]  oldDst,
  input  logic [XLEN-1:0]  srcA,
  input  logic [XLEN-1:0]  srcB,
  input  logic [7:0]       truthTbl,
  input  logic             recordEn,
  input  logic             sumOvf,
  output logic             resValid,
  output logic [XLEN-1:0]  result,
  output logic             condValid,
  output logic [3:0]       condField
);
  tluStrobe_t strb;

  tlu_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .recordEn(recordEn),
    .strb(strb), .resValid(resValid), .condValid(condValid)
  );

  tlu_datapath #(.XLEN(XLEN)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .oldDst(oldDst), .srcA(srcA),
    .srcB(srcB), .truthTbl(truthTbl), .sumOvf(sumOvf),
    .resQ(result), .condQ(condField)
  );
endmodule

// File: tb/tern_logic_unit_tb.sv
module tern_logic_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] oldDst = '0, srcA = '0, srcB = '0;
  logic [7:0]  truthTbl = '0;
  logic        recordEn = 1'b0, sumOvf = 1'b0;
  logic        resValid, condValid;
  logic [63:0] result;
  logic [3:0]  condField;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tern_logic_unit dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .oldDst(oldDst), .srcA(srcA),
    .srcB(srcB), .truthTbl(truthTbl), .recordEn(recordEn), .sumOvf(sumOvf),
    .resValid(resValid), .result(result), .condValid(condValid),
    .condField(condField)
  );

  // sum of products over the eight selector minterms (R1)
  function automatic logic [63:0] refFn(logic [63:0] d, logic [63:0] a,
                                        logic [63:0] b, logic [7:0] t);
    logic [63:0] acc = '0;
    for (int k = 0; k < 8; k++) begin
      logic [63:0] term;
      term = (k[2] ? d : ~d) & (k[1] ? a : ~a) & (k[0] ? b : ~b);
      acc |= term & {64{t[7-k]}};
    end
    return acc;
  endfunction

  function automatic logic [3:0] refCond(logic [63:0] r, logic so);
    return {$signed(r) < 0, $signed(r) > 0, r == 64'd0, so};
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // issue one operation; check outputs one cycle later
  task automatic issue(logic [63:0] d, logic [63:0] a, logic [63:0] b,
                       logic [7:0] t, logic rec, logic so, string tag);
    logic [63:0] exp;
    logic [3:0] prevCond;
    @(negedge clk);
    prevCond = condField;
    oldDst = d; srcA = a; srcB = b; truthTbl = t;
    recordEn = rec; sumOvf = so; inValid = 1'b1;
    exp = refFn(d, a, b, t);
    @(posedge clk); #1;
    chk(result == exp, tag, result, exp);
    chk(resValid == 1'b1, "R5 resValid", 64'(resValid), 64'd1);
    if (rec) begin
      chk(condValid == 1'b1 && condField == refCond(exp, so), "R6 cond",
          64'({condValid, condField}), 64'({1'b1, refCond(exp, so)}));
    end else begin
      chk(condValid == 1'b0 && condField == prevCond, "R7 cond held",
          64'({condValid, condField}), 64'({1'b0, prevCond}));
    end
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] d, a, b, heldRes;
    logic [3:0] heldCond;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1;
    chk(!resValid && !condValid && result == '0 && condField == '0,
        "R8 reset", {result[59:0], condField}, 64'd0);
    @(negedge clk); rstN = 1'b1;

    // R5 idle after reset
    @(posedge clk); #1;
    chk(resValid == 1'b0, "R5 idle", 64'(resValid), 64'd0);

    // R3 constant tables
    issue(64'hDEAD_BEEF_0123_4567, 64'hFFFF_0000_AAAA_5555, 64'h0F0F_F0F0_1234_8765,
          8'h00, 1'b1, 1'b0, "R3 table 00");
    issue(64'hDEAD_BEEF_0123_4567, 64'hFFFF_0000_AAAA_5555, 64'h0F0F_F0F0_1234_8765,
          8'hFF, 1'b1, 1'b1, "R3 table FF");

    // R1 single selector values: one-hot tables over exhaustive bit patterns
    for (int s = 0; s < 8; s++)
      issue(64'hF0F0_F0F0_F0F0_F0F0, 64'hCCCC_CCCC_CCCC_CCCC, 64'hAAAA_AAAA_AAAA_AAAA,
            8'(1 << s), 1'b0, 1'b0, "R1 onehot table");

    // R4 multiplexer and two-input tables
    d = {$urandom, $urandom}; a = {$urandom, $urandom}; b = {$urandom, $urandom};
    issue(d, a, b, 8'h1B, 1'b1, 1'b0, "R4 mux");
    chk(result == ((a & b) | (d & ~b)), "R4 mux form", result, (a & b) | (d & ~b));
    issue(d, a, b, 8'h11, 1'b0, 1'b0, "R4 and");
    chk(result == (a & b), "R4 and form", result, a & b);
    issue(d, a, b, 8'h77, 1'b0, 1'b0, "R4 or");
    chk(result == (a | b), "R4 or form", result, a | b);
    issue(d, a, b, 8'h66, 1'b0, 1'b0, "R4 xor");
    chk(result == (a ^ b), "R4 xor form", result, a ^ b);

    // R6 sign cases: negative, positive, zero
    issue(64'h8000_0000_0000_0000, 64'd0, 64'd0, 8'h0F, 1'b1, 1'b1, "R6 negative");
    issue(64'h0000_0000_0000_0001, 64'd0, 64'd0, 8'h0F, 1'b1, 1'b0, "R6 positive");
    issue(64'd5, 64'd0, 64'd0, 8'h00, 1'b1, 1'b1, "R6 zero");
    // R7 non-recording op leaves condField
    issue(64'h8000_0000_0000_0000, 64'd0, 64'd0, 8'h0F, 1'b0, 1'b0, "R7 result");

    // R9 inputs ignored while inValid low
    heldRes = result; heldCond = condField;
    @(negedge clk);
    oldDst = '1; srcA = '1; srcB = '0; truthTbl = 8'hA5; recordEn = 1'b1; sumOvf = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    chk(result == heldRes && condField == heldCond && !resValid,
        "R9 ignored", result, heldRes);

    // R2 all 256 tables on random operands
    for (int t = 0; t < 256; t++) begin
      for (int rep = 0; rep < 2; rep++) begin
        d = {$urandom, $urandom}; a = {$urandom, $urandom}; b = {$urandom, $urandom};
        issue(d, a, b, 8'(t), 1'($urandom), 1'($urandom), "R2 sweep");
      end
    end

    // R8 reset mid-run clears outputs
    issue('1, '1, '1, 8'hFF, 1'b1, 1'b1, "R3 before reset");
    @(negedge clk); rstN = 1'b0;
    @(posedge clk); #1;
    chk(!resValid && !condValid && result == '0 && condField == '0,
        "R8 reset again", {result[59:0], condField}, 64'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule